// File: doc/BRIEF.md
# Edge/Level Interrupt Router

This block sits between a bank of interrupt request lines and the message fabric that carries interrupts to processors. Each input pin owns a routing entry that names the vector, the delivery mode, the destination addressing mode, the trigger type, a mask and a destination identifier. The block keeps a pending bit and a remote-pending bit per pin. It picks one serviceable pin at a time and presents a delivery message on a registered valid/ready output.

Edge pins deliver once per rising transition of their line. Level pins deliver while their line is high, but after a delivery that reached at least one destination they are held off by their remote-pending bit. That bit clears when an end-of-interrupt broadcast carries the entry's vector and the level trigger type, or when the entry is reprogrammed. A level line that is still high is then served again without a new transition.

The block also keeps a 256-entry membership set of the vectors the table currently uses. The set is rebuilt after every table write and after reset, and a query port reports whether a given vector is in it.

Top module: `irq_route_core`

## Requirements
- R1: After reset every entry is masked, edge-triggered, with vector 0 and destination 0; no delivery is offered, `eoi_ack` is all zero, and the vector set holds only vector 0.
- R2: A low line clears its pin's pending bit, so a masked pin whose line rises and falls again produces no delivery when it is unmasked later.
- R3: An edge pin (`cfg_level`=0) delivers once per rising transition of its line. Its pending bit clears when the delivery is loaded into the output, and a line held high does not deliver again.
- R4: A level pin (`cfg_level`=1) with its line high is pending. After a handshake with `dlv_hit`=1 its remote-pending bit is set, and no further delivery is made from that pin while the bit is set.
- R5: A masked entry (`cfg_mask`=1) is never delivered, but its pending bit is kept; unmasking it while that bit is set yields a delivery.
- R6: In the cycle after an end-of-interrupt (`eoi_valid`=1), `eoi_ack` has a 1 at bit i for every entry i whose vector equals `eoi_vector`, and 0 elsewhere. When `eoi_level`=1, matching level entries lose their remote-pending bit, and a matching pin whose line is still high is delivered again. When `eoi_level`=0, remote-pending is untouched.
- R7: Writing an entry clears that pin's remote-pending bit, so a level pin whose line is still high is delivered again with the new contents.
- R8: When several pins are serviceable, the lowest pin number is delivered first, and exactly one delivery is made per accepted handshake.
- R9: The delivery fields (`dlv_pin`, `dlv_vector`, `dlv_mode`, `dlv_logical`, `dlv_level`, `dlv_dest`) are registered and held stable while `dlv_valid`=1 and `dlv_ready`=0.
- R10: Starting with the second cycle after a table write, `hv_hit` is 1 exactly when some entry's vector equals `hv_query`. A vector no longer used by any entry reads 0.
- R11: A write whose `cfg_pin` is `NUM_PINS` or above changes no entry.
- R12: A level delivery accepted with `dlv_hit`=0 leaves remote-pending clear, so the pin is offered again while its line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_line | input | NUM_PINS | Interrupt request lines, one per pin |
| cfg_we | input | 1 | Table write strobe |
| cfg_pin | input | PIN_W | Entry index for the write |
| cfg_vector | input | 8 | Vector field to write |
| cfg_mode | input | 3 | Delivery mode field to write |
| cfg_logical | input | 1 | Destination addressing mode field (1 = logical) |
| cfg_level | input | 1 | Trigger type field (1 = level, 0 = edge) |
| cfg_mask | input | 1 | Mask field (1 = masked) |
| cfg_dest | input | 8 | Destination identifier field |
| dlv_valid | output | 1 | Delivery message valid |
| dlv_ready | input | 1 | Delivery message accepted |
| dlv_hit | input | 1 | With the handshake: at least one destination accepted |
| dlv_pin | output | PIN_W | Pin being delivered |
| dlv_vector | output | 8 | Delivered vector |
| dlv_mode | output | 3 | Delivered delivery mode |
| dlv_logical | output | 1 | Delivered addressing mode |
| dlv_level | output | 1 | Delivered trigger type |
| dlv_dest | output | 8 | Delivered destination identifier |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | 8 | Vector being retired |
| eoi_level | input | 1 | Trigger type of the end-of-interrupt |
| eoi_ack | output | NUM_PINS | Per-entry acknowledge pulse, one cycle after the broadcast |
| hv_query | input | 8 | Vector to look up in the vector set |
| hv_hit | output | 1 | Queried vector is used by some entry |

## Verification
The bench builds the block with its default of 24 pins, so the 5-bit entry index also reaches the values 24 to 31 and the out-of-range write rule can be tested. With 24 entries, several pins can share one vector, so an end-of-interrupt can acknowledge more than one entry. Three pins can be raised together behind a stalled output, which exercises the lowest-first ordering and the hold rule. The 8-bit vectors give the full 256-entry membership set, with vector 0 present after reset.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int MODE_W = 3;

  // One routing entry of the table.
  typedef struct packed {
    logic [VEC_W-1:0]  vector;
    logic [MODE_W-1:0] dmode;
    logic              logical;
    logic              level;
    logic              mask;
    logic [DEST_W-1:0] dest;
  } rte_t;

  localparam rte_t RTE_RESET = '{
    vector:  '0,
    dmode:   '0,
    logical: 1'b0,
    level:   1'b0,
    mask:    1'b1,
    dest:    '0
  };

endpackage

// File: rtl/irq_pin_slot.sv
// Per-pin request state: line history, pending bit, remote-pending bit.
module irq_pin_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic level,
  input  logic take,
  input  logic set_rem,
  input  logic eoi_clr,
  input  logic wr_clr,
  output logic pend,
  output logic rem
);

  logic prev_q, pend_q, rem_q;
  logic prev_d, pend_d, rem_d;
  logic rise;

  assign rise = line & ~prev_q;

  always_comb begin
    prev_d = line;
    // A low line drops the request; an edge pin loses it when loaded.
    pend_d = line & ((pend_q & ~(take & ~level)) | rise | level);
    rem_d  = rem_q;
    if (wr_clr)       rem_d = 1'b0;
    else if (set_rem) rem_d = 1'b1;
    else if (eoi_clr) rem_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      rem_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
      rem_q  <= rem_d;
    end
  end

  assign pend = pend_q;
  assign rem  = rem_q;

endmodule

// File: rtl/irq_pick_lowest.sv
// Fixed-priority picker: lowest set request wins.
module irq_pick_lowest #(
  parameter int N  = 24,
  parameter int IW = 5
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/irq_vec_set.sv
// Membership set of the vectors used by the table, rebuilt on enable.
module irq_vec_set #(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rebuild,
  input  logic [NUM_PINS*VEC_W-1:0] vec_flat,
  input  logic [VEC_W-1:0]          query,
  output logic                      hit
);

  localparam int NVEC = 1 << VEC_W;

  logic [NVEC-1:0] set_q, set_d;

  always_comb begin
    set_d = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      set_d[vec_flat[p*VEC_W +: VEC_W]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       set_q <= NVEC'(1);
    else if (rebuild) set_q <= set_d;
  end

  assign hit = set_q[query];

endmodule

// File: rtl/irq_route_core.sv
module irq_route_core
  import irq_route_pkg::*;
#(
  parameter  int NUM_PINS = 24,
  localparam int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_line,
  input  logic                cfg_we,
  input  logic [PIN_W-1:0]    cfg_pin,
  input  logic [VEC_W-1:0]    cfg_vector,
  input  logic [MODE_W-1:0]   cfg_mode,
  input  logic                cfg_logical,
  input  logic                cfg_level,
  input  logic                cfg_mask,
  input  logic [DEST_W-1:0]   cfg_dest,
  output logic                dlv_valid,
  input  logic                dlv_ready,
  input  logic                dlv_hit,
  output logic [PIN_W-1:0]    dlv_pin,
  output logic [VEC_W-1:0]    dlv_vector,
  output logic [MODE_W-1:0]   dlv_mode,
  output logic                dlv_logical,
  output logic                dlv_level,
  output logic [DEST_W-1:0]   dlv_dest,
  input  logic                eoi_valid,
  input  logic [VEC_W-1:0]    eoi_vector,
  input  logic                eoi_level,
  output logic [NUM_PINS-1:0] eoi_ack,
  input  logic [VEC_W-1:0]    hv_query,
  output logic                hv_hit
);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  rte_t                      tbl_q [NUM_PINS];
  rte_t                      cfg_ent;
  logic                      cfg_in_range;
  logic [NUM_PINS-1:0]       wr_hit, pend_vec, rem_vec, elig, take, set_rem;
  logic [NUM_PINS-1:0]       eoi_match, eoi_clr, mask_vec, level_vec;
  logic [NUM_PINS*VEC_W-1:0] vec_flat;
  logic                      pick_any, load_en, hs;
  logic [PIN_W-1:0]          pick_idx;

  rte_t                      out_ent_q, out_ent_d;
  logic [PIN_W-1:0]          out_pin_q, out_pin_d;
  logic                      out_valid_q, out_valid_d;
  logic [NUM_PINS-1:0]       eoi_ack_q;
  logic                      wr_seen_q;

  assign cfg_ent = '{
    vector:  cfg_vector,
    dmode:   cfg_mode,
    logical: cfg_logical,
    level:   cfg_level,
    mask:    cfg_mask,
    dest:    cfg_dest
  };

  assign cfg_in_range = ({{(32-PIN_W){1'b0}}, cfg_pin} < 32'(NUM_PINS));
  assign hs           = out_valid_q & dlv_ready;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign wr_hit[i] = cfg_we & cfg_in_range & (cfg_pin == PIN_W'(i));

    always_ff @(posedge clk or negedge rst_core_n) begin
      if (!rst_core_n)    tbl_q[i] <= RTE_RESET;
      else if (wr_hit[i]) tbl_q[i] <= cfg_ent;
    end

    assign mask_vec[i]                    = tbl_q[i].mask;
    assign level_vec[i]                   = tbl_q[i].level;
    assign vec_flat[i*VEC_W +: VEC_W]     = tbl_q[i].vector;
    assign eoi_match[i] = eoi_valid & (tbl_q[i].vector == eoi_vector);
    assign eoi_clr[i]   = eoi_match[i] & eoi_level & tbl_q[i].level;
    assign elig[i]      = pend_vec[i] & ~tbl_q[i].mask
                          & ~(tbl_q[i].level & rem_vec[i]);
    assign take[i]      = load_en & (pick_idx == PIN_W'(i));
    assign set_rem[i]   = hs & (out_pin_q == PIN_W'(i))
                          & out_ent_q.level & dlv_hit;

    irq_pin_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .line    (irq_line[i]),
      .level   (tbl_q[i].level),
      .take    (take[i]),
      .set_rem (set_rem[i]),
      .eoi_clr (eoi_clr[i]),
      .wr_clr  (wr_hit[i]),
      .pend    (pend_vec[i]),
      .rem     (rem_vec[i])
    );
  end

  irq_pick_lowest #(.N(NUM_PINS), .IW(PIN_W)) u_pick (
    .req (elig),
    .any (pick_any),
    .idx (pick_idx)
  );

  // A new message is loaded only into an empty output register.
  assign load_en = pick_any & ~out_valid_q;

  always_comb begin
    out_valid_d = out_valid_q;
    out_ent_d   = out_ent_q;
    out_pin_d   = out_pin_q;
    if (hs) out_valid_d = 1'b0;
    if (load_en) begin
      out_valid_d = 1'b1;
      out_ent_d   = tbl_q[pick_idx];
      out_pin_d   = pick_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      out_valid_q <= 1'b0;
      out_ent_q   <= RTE_RESET;
      out_pin_q   <= '0;
      eoi_ack_q   <= '0;
      wr_seen_q   <= 1'b1;
    end else begin
      out_valid_q <= out_valid_d;
      out_ent_q   <= out_ent_d;
      out_pin_q   <= out_pin_d;
      eoi_ack_q   <= eoi_match;
      wr_seen_q   <= |wr_hit;
    end
  end

  irq_vec_set #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W)) u_vset (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rebuild  (wr_seen_q),
    .vec_flat (vec_flat),
    .query    (hv_query),
    .hit      (hv_hit)
  );

  assign dlv_valid   = out_valid_q;
  assign dlv_pin     = out_pin_q;
  assign dlv_vector  = out_ent_q.vector;
  assign dlv_mode    = out_ent_q.dmode;
  assign dlv_logical = out_ent_q.logical;
  assign dlv_level   = out_ent_q.level;
  assign dlv_dest    = out_ent_q.dest;
  assign eoi_ack     = eoi_ack_q;

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_we,
  input logic                dlv_valid,
  input logic                dlv_ready,
  input logic                dlv_hit,
  input logic [PIN_W-1:0]    dlv_pin,
  input logic [VEC_W-1:0]    dlv_vector,
  input logic [DEST_W-1:0]   dlv_dest,
  input logic [MODE_W-1:0]   dlv_mode,
  input logic                dlv_logical,
  input logic                dlv_level,
  input logic                eoi_valid,
  input logic [NUM_PINS-1:0] eoi_ack,
  input logic                load_en,
  input logic [PIN_W-1:0]    pick_idx,
  input logic [NUM_PINS-1:0] elig,
  input logic [NUM_PINS-1:0] pend_vec,
  input logic [NUM_PINS-1:0] rem_vec,
  input logic [NUM_PINS-1:0] mask_vec,
  input logic [NUM_PINS-1:0] level_vec
);

  logic [NUM_PINS-1:0] below_pick;
  assign below_pick = ({{(NUM_PINS-1){1'b0}}, 1'b1} << pick_idx) - 1'b1;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_pin) &&
      $stable(dlv_vector) && $stable(dlv_dest) && $stable(dlv_mode) &&
      $stable(dlv_logical) && $stable(dlv_level)));

  assert_no_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> !mask_vec[pick_idx]);

  assert_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> ((elig & below_pick) == '0));

  assert_edge_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !level_vec[pick_idx]) |=> !pend_vec[$past(pick_idx)]);

  assert_remote_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_ready && dlv_level && dlv_hit && !cfg_we)
      |=> rem_vec[$past(dlv_pin)]);

  assert_ack_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !eoi_valid |=> (eoi_ack == '0));

endmodule

bind irq_route_core irq_route_chk #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .cfg_we      (cfg_we),
  .dlv_valid   (dlv_valid),
  .dlv_ready   (dlv_ready),
  .dlv_hit     (dlv_hit),
  .dlv_pin     (dlv_pin),
  .dlv_vector  (dlv_vector),
  .dlv_dest    (dlv_dest),
  .dlv_mode    (dlv_mode),
  .dlv_logical (dlv_logical),
  .dlv_level   (dlv_level),
  .eoi_valid   (eoi_valid),
  .eoi_ack     (eoi_ack),
  .load_en     (load_en),
  .pick_idx    (pick_idx),
  .elig        (elig),
  .pend_vec    (pend_vec),
  .rem_vec     (rem_vec),
  .mask_vec    (mask_vec),
  .level_vec   (level_vec)
);

// File: tb/tb_irq_route_core.sv
`timescale 1ns/1ps
module tb_irq_route_core;

  localparam int NP = 24;
  localparam int PW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] irq_line;
  logic          cfg_we;
  logic [PW-1:0] cfg_pin;
  logic [7:0]    cfg_vector;
  logic [2:0]    cfg_mode;
  logic          cfg_logical, cfg_level, cfg_mask;
  logic [7:0]    cfg_dest;
  logic          dlv_valid, dlv_ready, dlv_hit;
  logic [PW-1:0] dlv_pin;
  logic [7:0]    dlv_vector;
  logic [2:0]    dlv_mode;
  logic          dlv_logical, dlv_level;
  logic [7:0]    dlv_dest;
  logic          eoi_valid;
  logic [7:0]    eoi_vector;
  logic          eoi_level;
  logic [NP-1:0] eoi_ack;
  logic [7:0]    hv_query;
  logic          hv_hit;

  always #2 clk = ~clk;

  irq_route_core #(.NUM_PINS(NP)) dut (.*);

  int n_chk = 0;
  int n_fail = 0;
  int n_seen = 0;
  logic [25:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [25:0] pack(input logic [PW-1:0] p, input logic [7:0] v,
                                       input logic [2:0] m, input logic lg,
                                       input logic lv, input logic [7:0] d);
    return {p, v, m, lg, lv, d};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_ent(input logic [PW-1:0] p, input logic [7:0] v, input logic [2:0] m,
                           input logic lg, input logic lv, input logic mk, input logic [7:0] d);
    cfg_we = 1'b1; cfg_pin = p; cfg_vector = v; cfg_mode = m;
    cfg_logical = lg; cfg_level = lv; cfg_mask = mk; cfg_dest = d;
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic expect_dlv(input string tag, input logic [25:0] e);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic send_eoi(input logic [7:0] v, input logic lv);
    eoi_valid = 1'b1; eoi_vector = v; eoi_level = lv;
    cyc(1);
    eoi_valid = 1'b0;
  endtask

  // Monitor: compare each accepted delivery with the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && dlv_valid && dlv_ready) begin
      n_seen++;
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R8: unexpected delivery actual %h expected none",
                 pack(dlv_pin, dlv_vector, dlv_mode, dlv_logical, dlv_level, dlv_dest));
      end else begin
        chk(tag_q.pop_front(),
            32'(pack(dlv_pin, dlv_vector, dlv_mode, dlv_logical, dlv_level, dlv_dest)),
            32'(exp_q.pop_front()));
      end
    end
  end

  bit done = 1'b0;
  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    logic [25:0] held;
    rst_n = 1'b0; irq_line = '0; cfg_we = 1'b0; cfg_pin = '0; cfg_vector = '0;
    cfg_mode = '0; cfg_logical = 1'b0; cfg_level = 1'b0; cfg_mask = 1'b0; cfg_dest = '0;
    dlv_ready = 1'b1; dlv_hit = 1'b1; eoi_valid = 1'b0; eoi_vector = '0; eoi_level = 1'b0;
    hv_query = 8'h00;
    cyc(3);
    rst_n = 1'b1;
    cyc(5);

    // R1: reset state
    chk("R1 valid", 32'(dlv_valid), 32'd0);
    chk("R1 ack", 32'(eoi_ack), 32'd0);
    chk("R1 set has 0", 32'(hv_hit), 32'd1);
    hv_query = 8'h40; #1;
    chk("R1 set lacks 0x40", 32'(hv_hit), 32'd0);

    // R2: masked pin rises and falls; unmasking later gives nothing
    base = n_seen;
    irq_line[3] = 1'b1; cyc(5);
    irq_line[3] = 1'b0; cyc(2);
    write_ent(5'd3, 8'h33, 3'd0, 1'b0, 1'b0, 1'b0, 8'h01);
    cyc(6);
    chk("R2 no delivery", 32'(n_seen - base), 32'd0);

    // R3: edge pin held high delivers once
    base = n_seen;
    expect_dlv("R3 edge", pack(5'd3, 8'h33, 3'd0, 1'b0, 1'b0, 8'h01));
    irq_line[3] = 1'b1; cyc(12);
    chk("R3 single delivery", 32'(n_seen - base), 32'd1);
    irq_line[3] = 1'b0; cyc(2);

    // R5: masked edge request kept, delivered on unmask
    base = n_seen;
    write_ent(5'd5, 8'h55, 3'd2, 1'b1, 1'b0, 1'b1, 8'h05);
    irq_line[5] = 1'b1; cyc(6);
    chk("R5 masked silent", 32'(n_seen - base), 32'd0);
    expect_dlv("R5 unmask", pack(5'd5, 8'h55, 3'd2, 1'b1, 1'b0, 8'h05));
    write_ent(5'd5, 8'h55, 3'd2, 1'b1, 1'b0, 1'b0, 8'h05);
    cyc(6);
    chk("R5 one delivery", 32'(n_seen - base), 32'd1);
    irq_line[5] = 1'b0; cyc(2);

    // R4 / R6: level pin, remote pending, end-of-interrupt
    write_ent(5'd9, 8'h77, 3'd0, 1'b0, 1'b0, 1'b1, 8'h09);
    write_ent(5'd7, 8'h77, 3'd1, 1'b1, 1'b1, 1'b0, 8'h12);
    base = n_seen;
    expect_dlv("R4 level", pack(5'd7, 8'h77, 3'd1, 1'b1, 1'b1, 8'h12));
    irq_line[7] = 1'b1; cyc(12);
    chk("R4 held by remote", 32'(n_seen - base), 32'd1);
    send_eoi(8'h77, 1'b0);
    chk("R6 ack both matches", 32'(eoi_ack), 32'h000280);
    cyc(8);
    chk("R6 edge eoi keeps remote", 32'(n_seen - base), 32'd1);
    expect_dlv("R6 level eoi redeliver", pack(5'd7, 8'h77, 3'd1, 1'b1, 1'b1, 8'h12));
    send_eoi(8'h77, 1'b1);
    cyc(8);
    chk("R6 redelivered once", 32'(n_seen - base), 32'd2);
    irq_line[7] = 1'b0; cyc(2);
    send_eoi(8'h77, 1'b1);
    cyc(8);
    chk("R6 no redeliver when low", 32'(n_seen - base), 32'd2);

    // R7: reprogramming clears remote pending
    base = n_seen;
    expect_dlv("R7 first", pack(5'd7, 8'h77, 3'd1, 1'b1, 1'b1, 8'h12));
    irq_line[7] = 1'b1; cyc(8);
    expect_dlv("R7 after write", pack(5'd7, 8'h78, 3'd1, 1'b1, 1'b1, 8'h13));
    write_ent(5'd7, 8'h78, 3'd1, 1'b1, 1'b1, 1'b0, 8'h13);
    cyc(8);
    chk("R7 two deliveries", 32'(n_seen - base), 32'd2);
    irq_line[7] = 1'b0; cyc(2);
    send_eoi(8'h78, 1'b1);
    cyc(4);

    // R8 / R9: simultaneous requests behind a stalled output
    write_ent(5'd10, 8'hA0, 3'd0, 1'b0, 1'b0, 1'b0, 8'h0A);
    write_ent(5'd11, 8'hA1, 3'd0, 1'b0, 1'b0, 1'b0, 8'h0B);
    write_ent(5'd12, 8'hA2, 3'd0, 1'b0, 1'b0, 1'b0, 8'h0C);
    base = n_seen;
    dlv_ready = 1'b0;
    irq_line[12] = 1'b1; irq_line[10] = 1'b1; irq_line[11] = 1'b1;
    cyc(5);
    held = pack(dlv_pin, dlv_vector, dlv_mode, dlv_logical, dlv_level, dlv_dest);
    chk("R9 valid while stalled", 32'(dlv_valid), 32'd1);
    cyc(3);
    chk("R9 fields held", 32'(pack(dlv_pin, dlv_vector, dlv_mode, dlv_logical,
                                   dlv_level, dlv_dest)), 32'(held));
    expect_dlv("R8 order pin10", pack(5'd10, 8'hA0, 3'd0, 1'b0, 1'b0, 8'h0A));
    expect_dlv("R8 order pin11", pack(5'd11, 8'hA1, 3'd0, 1'b0, 1'b0, 8'h0B));
    expect_dlv("R8 order pin12", pack(5'd12, 8'hA2, 3'd0, 1'b0, 1'b0, 8'h0C));
    dlv_ready = 1'b1;
    cyc(12);
    chk("R8 three deliveries", 32'(n_seen - base), 32'd3);
    irq_line[10] = 1'b0; irq_line[11] = 1'b0; irq_line[12] = 1'b0; cyc(2);

    // R12: accepted with no destination, offered again
    write_ent(5'd14, 8'hE0, 3'd4, 1'b0, 1'b1, 1'b0, 8'h0E);
    base = n_seen;
    dlv_ready = 1'b0;
    expect_dlv("R12 first", pack(5'd14, 8'hE0, 3'd4, 1'b0, 1'b1, 8'h0E));
    expect_dlv("R12 again", pack(5'd14, 8'hE0, 3'd4, 1'b0, 1'b1, 8'h0E));
    irq_line[14] = 1'b1; cyc(4);
    dlv_hit = 1'b0; dlv_ready = 1'b1; cyc(1);
    dlv_ready = 1'b0; dlv_hit = 1'b1; cyc(4);
    chk("R12 offered again", 32'(dlv_valid), 32'd1);
    dlv_ready = 1'b1; cyc(10);
    chk("R12 then held by remote", 32'(n_seen - base), 32'd2);
    irq_line[14] = 1'b0; cyc(2);
    send_eoi(8'hE0, 1'b1);
    cyc(4);

    // R10 / R11: vector set and out-of-range writes
    write_ent(5'd30, 8'h99, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00);
    cyc(3);
    hv_query = 8'h99; #1;
    chk("R11 out-of-range ignored", 32'(hv_hit), 32'd0);
    write_ent(5'd20, 8'h99, 3'd0, 1'b0, 1'b0, 1'b1, 8'h00);
    cyc(3);
    chk("R10 new vector present", 32'(hv_hit), 32'd1);
    write_ent(5'd3, 8'h3C, 3'd0, 1'b0, 1'b0, 1'b0, 8'h01);
    cyc(3);
    hv_query = 8'h33; #1;
    chk("R10 replaced vector gone", 32'(hv_hit), 32'd0);
    hv_query = 8'h3C; #1;
    chk("R10 replacement present", 32'(hv_hit), 32'd1);

    cyc(4);
    chk("R8 scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule